// File: doc/BRIEF.md
# Base and Bounds Address Relocator

This block sits between a core's address generation and its memory port. Each memory request carries an effective address and an access kind. In the same cycle, the block either forwards a physical address or raises a bounds trap. The physical address is the segment base plus the effective address. A trap is raised when the effective address falls outside the segment, or when the sum runs past the top of the address space. When a trap is raised, no physical access is issued.

The block holds a privilege mode: 0 is user and 1 is supervisor. Only supervisor code may change the segment registers or read them back. A register write attempted in user mode is dropped, and a one-cycle privilege-violation flag is raised. Translation keeps using the unchanged registers. A trap-entry input switches the block to supervisor, and a return input switches it back to user. Out of reset the block is in supervisor mode with both registers at zero, so every request traps until the registers are programmed.

Top module: `bb_relocator`

## Requirements
- R1: When `req_valid` is high and no violation exists, `phys_valid` is high in the same cycle. `phys_addr` equals (base + `req_ea`) modulo 2^ADDR_W, and `phys_kind` equals `req_kind`.
- R2: When `req_valid` is high and `req_ea` >= bound (unsigned), `trap_bounds` is high and `phys_valid` is low in the same cycle.
- R3: With WRAP_FAULT=1, a request whose base + `req_ea` carries past 2^ADDR_W - 1 raises `trap_bounds` and not `phys_valid`, even when `req_ea` < bound.
- R4: A register write (`wr_en` high) made while in user mode leaves both base and bound unchanged.
- R5: In supervisor mode, a write lands at the next clock edge. `wr_sel`=0 writes base and `wr_sel`=1 writes bound. `rd_data` shows the register picked by `rd_sel` (same encoding) in supervisor mode and reads 0 in user mode.
- R6: `priv_viol` is high for exactly the cycle after each clock edge at which a user-mode write was refused, and is low otherwise.
- R7: `mode_super` is 1 in supervisor mode. `trap_enter` sets supervisor at the next edge, and `trap_return` sets user at the next edge. When both are high, `trap_enter` wins.
- R8: After reset, `mode_super`=1, base=0, bound=0 and `priv_viol`=0, so every request traps.
- R9: When `req_valid` is low, both `phys_valid` and `trap_bounds` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Memory request present |
| req_ea | input | ADDR_W | Effective address |
| req_kind | input | 2 | Access kind (0 load, 1 store, 2 fetch) |
| phys_valid | output | 1 | Physical access issued |
| phys_addr | output | ADDR_W | Relocated address |
| phys_kind | output | 2 | Access kind forwarded |
| trap_bounds | output | 1 | Bounds violation trap |
| wr_en | input | 1 | Segment register write request |
| wr_sel | input | 1 | 0 base, 1 bound |
| wr_data | input | ADDR_W | Write value |
| rd_sel | input | 1 | 0 base, 1 bound |
| rd_data | output | ADDR_W | Readback value, 0 in user mode |
| trap_enter | input | 1 | Switch to supervisor |
| trap_return | input | 1 | Switch to user |
| mode_super | output | 1 | 1 supervisor, 0 user |
| priv_viol | output | 1 | Refused user-mode write, one cycle |

## Verification
The bench builds the block with ADDR_W=8 and WRAP_FAULT=1. With that width, every one of the 256 effective addresses can be swept against several base and bound pairs. The pairs include a zero bound, a full bound, a base near the top of the address space, and a bound of one. Together they reach every combination of the limit test and the carry test, and the expected outcome is computed arithmetically. The narrow width also keeps the mode, write-refusal and readback sequences short, so their outcomes can be checked through translation results and `rd_data`.

// File: rtl/bb_reloc_pkg.sv
package bb_reloc_pkg;

   typedef enum logic {
      MODE_USER  = 1'b0,
      MODE_SUPER = 1'b1
   } priv_mode_e;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_FETCH = 2'd2
   } acc_kind_e;

   localparam logic SEL_BASE  = 1'b0;
   localparam logic SEL_BOUND = 1'b1;

endpackage

// File: rtl/bb_mode_ctl.sv
module bb_mode_ctl
   import bb_reloc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enter_i,
   input  logic       return_i,
   output priv_mode_e mode_o
);

   priv_mode_e mode_d;

   always_comb begin
      mode_d = mode_o;
      if (enter_i)       mode_d = MODE_SUPER;
      else if (return_i) mode_d = MODE_USER;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_o <= MODE_SUPER;
      else        mode_o <= mode_d;
   end

endmodule

// File: rtl/bb_seg_regs.sv
module bb_seg_regs
   import bb_reloc_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  priv_mode_e        mode_i,
   input  logic              wr_en_i,
   input  logic              wr_sel_i,
   input  logic [ADDR_W-1:0] wr_data_i,
   input  logic              rd_sel_i,
   output logic [ADDR_W-1:0] rd_data_o,
   output logic [ADDR_W-1:0] base_o,
   output logic [ADDR_W-1:0] bound_o,
   output logic              viol_o
);

   logic grant;
   logic refuse;

   assign grant  = wr_en_i && (mode_i == MODE_SUPER);
   assign refuse = wr_en_i && (mode_i == MODE_USER);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_o  <= '0;
         bound_o <= '0;
         viol_o  <= 1'b0;
      end else begin
         viol_o <= refuse;
         if (grant && wr_sel_i == SEL_BASE)  base_o  <= wr_data_i;
         if (grant && wr_sel_i == SEL_BOUND) bound_o <= wr_data_i;
      end
   end

   always_comb begin
      rd_data_o = '0;
      if (mode_i == MODE_SUPER)
         rd_data_o = (rd_sel_i == SEL_BOUND) ? bound_o : base_o;
   end

endmodule

// File: rtl/bb_xlate.sv
module bb_xlate
   import bb_reloc_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter bit WRAP_FAULT = 1'b1
) (
   input  logic              valid_i,
   input  logic [ADDR_W-1:0] ea_i,
   input  logic [1:0]        kind_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [ADDR_W-1:0] bound_i,
   output logic              pvalid_o,
   output logic [ADDR_W-1:0] paddr_o,
   output logic [1:0]        pkind_o,
   output logic              trap_o
);

   localparam int SUM_W = ADDR_W + 1;

   logic [SUM_W-1:0] sum;
   logic             over_limit;
   logic             wrap_bad;

   assign sum        = {1'b0, base_i} + {1'b0, ea_i};
   assign over_limit = (ea_i >= bound_i);

   generate
      if (WRAP_FAULT) begin : g_wrap_fault
         assign wrap_bad = sum[ADDR_W];
      end else begin : g_wrap_quiet
         assign wrap_bad = 1'b0;
      end
   endgenerate

   assign paddr_o  = sum[ADDR_W-1:0];
   assign pkind_o  = kind_i;
   assign trap_o   = valid_i && (over_limit || wrap_bad);
   assign pvalid_o = valid_i && !(over_limit || wrap_bad);

endmodule

// File: rtl/bb_relocator.sv
module bb_relocator
   import bb_reloc_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter bit WRAP_FAULT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_ea,
   input  logic [1:0]        req_kind,
   output logic              phys_valid,
   output logic [ADDR_W-1:0] phys_addr,
   output logic [1:0]        phys_kind,
   output logic              trap_bounds,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic              rd_sel,
   output logic [ADDR_W-1:0] rd_data,
   input  logic              trap_enter,
   input  logic              trap_return,
   output logic              mode_super,
   output logic              priv_viol
);

   generate
      if (ADDR_W < 2 || ADDR_W > 64) begin : g_bad_width
         $error("bb_relocator: ADDR_W must lie in 2..64");
      end
   endgenerate

   priv_mode_e        mode_q;
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] bound_q;

   bb_mode_ctl u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .enter_i  (trap_enter),
      .return_i (trap_return),
      .mode_o   (mode_q)
   );

   bb_seg_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_i    (mode_q),
      .wr_en_i   (wr_en),
      .wr_sel_i  (wr_sel),
      .wr_data_i (wr_data),
      .rd_sel_i  (rd_sel),
      .rd_data_o (rd_data),
      .base_o    (base_q),
      .bound_o   (bound_q),
      .viol_o    (priv_viol)
   );

   bb_xlate #(.ADDR_W(ADDR_W), .WRAP_FAULT(WRAP_FAULT)) u_xlate (
      .valid_i  (req_valid),
      .ea_i     (req_ea),
      .kind_i   (req_kind),
      .base_i   (base_q),
      .bound_i  (bound_q),
      .pvalid_o (phys_valid),
      .paddr_o  (phys_addr),
      .pkind_o  (phys_kind),
      .trap_o   (trap_bounds)
   );

   assign mode_super = (mode_q == MODE_SUPER);

endmodule

// File: rtl/bb_relocator_chk.sv
module bb_relocator_chk
   import bb_reloc_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_ea,
   input logic              phys_valid,
   input logic [ADDR_W-1:0] phys_addr,
   input logic              trap_bounds,
   input logic              wr_en,
   input logic              trap_enter,
   input logic              mode_super,
   input logic              priv_viol,
   input logic [ADDR_W-1:0] base_q,
   input logic [ADDR_W-1:0] bound_q
);

   AST_PA_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      phys_valid |-> (phys_addr == ADDR_W'(base_q + req_ea))); // R1
   AST_LIMIT_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ea >= bound_q) |-> (trap_bounds && !phys_valid)); // R2
   AST_USER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_super |=> ($stable(base_q) && $stable(bound_q))); // R4
   AST_VIOL_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !mode_super) |=> priv_viol); // R6
   AST_VIOL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      priv_viol |-> $past(wr_en && !mode_super)); // R6
   AST_ENTER_SUPER: assert property (@(posedge clk) disable iff (!rst_n)
      trap_enter |=> mode_super); // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (!phys_valid && !trap_bounds)); // R9

endmodule

bind bb_relocator bb_relocator_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ea      (req_ea),
   .phys_valid  (phys_valid),
   .phys_addr   (phys_addr),
   .trap_bounds (trap_bounds),
   .wr_en       (wr_en),
   .trap_enter  (trap_enter),
   .mode_super  (mode_super),
   .priv_viol   (priv_viol),
   .base_q      (base_q),
   .bound_q     (bound_q)
);

// File: tb/bb_relocator_tb_top.sv
module bb_relocator_tb_top;

   localparam int AW  = 8;
   localparam int TOP = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_ea = '0;
   logic [1:0]    req_kind = '0;
   logic          phys_valid;
   logic [AW-1:0] phys_addr;
   logic [1:0]    phys_kind;
   logic          trap_bounds;
   logic          wr_en = 1'b0;
   logic          wr_sel = 1'b0;
   logic [AW-1:0] wr_data = '0;
   logic          rd_sel = 1'b0;
   logic [AW-1:0] rd_data;
   logic          trap_enter = 1'b0;
   logic          trap_return = 1'b0;
   logic          mode_super;
   logic          priv_viol;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   bb_relocator #(.ADDR_W(AW), .WRAP_FAULT(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ea(req_ea), .req_kind(req_kind),
      .phys_valid(phys_valid), .phys_addr(phys_addr), .phys_kind(phys_kind),
      .trap_bounds(trap_bounds),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data),
      .trap_enter(trap_enter), .trap_return(trap_return),
      .mode_super(mode_super), .priv_viol(priv_viol)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic reg_write(input logic sel, input int val);
      wr_en = 1'b1; wr_sel = sel; wr_data = AW'(val);
      tick();
      wr_en = 1'b0;
   endtask

   // Sweep every effective address against the given segment.
   task automatic sweep(input int base, input int bound);
      for (int ea = 0; ea < TOP; ea++) begin
         int  sum;
         bit  lim;
         bit  wrp;
         req_valid = 1'b1; req_ea = AW'(ea); req_kind = 2'(ea % 3);
         #1;
         sum = base + ea;
         lim = (ea >= bound);
         wrp = (sum >= TOP);
         if (lim) begin
            chk(trap_bounds && !phys_valid, "R2 limit trap", {trap_bounds, phys_valid}, 2);
         end else if (wrp) begin
            chk(trap_bounds && !phys_valid, "R3 wrap trap", {trap_bounds, phys_valid}, 2);
         end else begin
            chk(phys_valid && !trap_bounds, "R1 valid", {phys_valid, trap_bounds}, 2);
            chk(int'(phys_addr) == sum, "R1 addr", int'(phys_addr), sum);
            chk(int'(phys_kind) == ea % 3, "R1 kind", int'(phys_kind), ea % 3);
         end
      end
      req_valid = 1'b0;
      #1;
      chk(!phys_valid && !trap_bounds, "R9 idle", {phys_valid, trap_bounds}, 0);
   endtask

   initial begin
      #200000;
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      // R8 reset state
      chk(mode_super == 1'b1, "R8 mode", mode_super, 1);
      chk(priv_viol == 1'b0, "R8 viol", priv_viol, 0);
      rd_sel = 1'b0; #1;
      chk(rd_data == 0, "R8 base", rd_data, 0);
      rd_sel = 1'b1; #1;
      chk(rd_data == 0, "R8 bound", rd_data, 0);
      sweep(0, 0);

      // R5 supervisor writes and readback
      reg_write(1'b0, 16'h10);
      reg_write(1'b1, 16'h40);
      rd_sel = 1'b0; #1;
      chk(rd_data == 8'h10, "R5 base read", rd_data, 16);
      rd_sel = 1'b1; #1;
      chk(rd_data == 8'h40, "R5 bound read", rd_data, 64);
      sweep(16'h10, 16'h40);

      reg_write(1'b0, 16'hF0); reg_write(1'b1, 16'h20); sweep(16'hF0, 16'h20);
      reg_write(1'b0, 16'h00); reg_write(1'b1, 16'hFF); sweep(16'h00, 16'hFF);
      reg_write(1'b0, 16'h80); reg_write(1'b1, 16'h80); sweep(16'h80, 16'h80);
      reg_write(1'b0, 16'hFF); reg_write(1'b1, 16'h01); sweep(16'hFF, 16'h01);
      reg_write(1'b0, 16'h30); reg_write(1'b1, 16'h50);

      // R7 return to user
      trap_return = 1'b1; tick(); trap_return = 1'b0;
      chk(mode_super == 1'b0, "R7 return", mode_super, 0);
      chk(rd_data == 0, "R5 user read zero", rd_data, 0);

      // R4 / R6 refused writes
      chk(priv_viol == 1'b0, "R6 quiet before", priv_viol, 0);
      reg_write(1'b0, 16'h00);
      chk(priv_viol == 1'b1, "R6 flag", priv_viol, 1);
      reg_write(1'b1, 16'hFF);
      chk(priv_viol == 1'b1, "R6 flag again", priv_viol, 1);
      tick();
      chk(priv_viol == 1'b0, "R6 drop", priv_viol, 0);
      sweep(16'h30, 16'h50); // R4 translation still uses old segment

      // R7 both asserted: entry wins
      trap_enter = 1'b1; trap_return = 1'b1; tick();
      trap_enter = 1'b0; trap_return = 1'b0;
      chk(mode_super == 1'b1, "R7 enter wins", mode_super, 1);
      rd_sel = 1'b0; #1;
      chk(rd_data == 8'h30, "R4 base kept", rd_data, 48);
      rd_sel = 1'b1; #1;
      chk(rd_data == 8'h50, "R4 bound kept", rd_data, 80);
      chk(priv_viol == 1'b0, "R6 no flag in supervisor", priv_viol, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule